// File: doc/BRIEF.md
# Serial Frame Receiver with Status Readback

This block is the serial slave port of a driver controller. An external host selects the port by pulling an active-low select line low. It then clocks in a 16-bit command word on the data input and at the same time clocks out one of two 16-bit status words on the data output. All three serial inputs pass through synchronizers into the system clock domain. Their edges are detected there, so the serial clock must be several times slower than the system clock.

When the select line rises, a command of exactly 16 bits is committed to the frame register, and a one-cycle commit strobe tells downstream logic that the register has new contents. Bits beyond the sixteenth are dropped. A frame with fewer than 16 bits is thrown away. Bit 0 of the last committed command chooses which status word the next transfer returns. While the port is selected and before the first falling serial clock edge, the data output carries a no-fault flag. This lets the host poll for faults by only pulsing the select line.

The committed word is a plain register that holds until the next valid frame. The commit strobe has no ready and cannot be stalled, so a consumer that needs the word must capture it on the strobe or read the held register later.

Top module: `spi_frame_slave`

## Requirements
- R1: After reset, `miso_oe` and `frame_commit` are 0 and `frame_data` is 0.
- R2: `mosi` is sampled on each rising `sck` edge while `cs_n` is low, first bit into the MSB. After `cs_n` rises on a 16-bit frame, `frame_data` equals the 16 bits in the order they were sent.
- R3: In a frame of more than 16 rising `sck` edges, only the first 16 bits are kept and the trailing bits have no effect on `frame_data`.
- R4: A frame with fewer than 16 rising `sck` edges produces no commit and leaves `frame_data` unchanged.
- R5: Every valid 16-bit frame produces exactly one `frame_commit` pulse, one system clock wide, after `cs_n` rises.
- R6: `miso_oe` is 1 while `cs_n` is low and 0 while `cs_n` is high, each after the synchronizer delay of three system clocks.
- R7: While selected and before the first falling `sck` edge, `miso` carries the no-fault flag. The flag is 1 when bits 14 down to 1 of both status inputs are all 0, and 0 otherwise.
- R8: After the n-th falling `sck` edge of a frame (n = 1..16), `miso` shows bit 16-n of the returned word, MSB first. Bit 0 of the returned word is replaced by the no-fault flag.
- R9: The returned word comes from `status1_i` when bit 0 of the last committed frame is 1, and from `status0_i` when it is 0. After reset, `status0_i` is used.
- R10: The returned word is captured at the first rising `sck` edge of the frame. Later changes on the status inputs do not alter the bits shifted out in that frame.
- R11: `sck` edges while `cs_n` is high are ignored: they neither add bits to the next frame nor cause a commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low, asynchronous |
| sck | input | 1 | Serial clock, asynchronous |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out value |
| miso_oe | output | 1 | Output enable for the `miso` pad driver (0 = high impedance) |
| status0_i | input | 16 | Status word 0 |
| status1_i | input | 16 | Status word 1 |
| frame_data | output | 16 | Last committed command word |
| frame_commit | output | 1 | One-cycle strobe on each committed frame |

## Verification
The commit of a finished frame and the output shifter's reaction to a falling serial clock can land in the same system cycle. This happens when the host releases `cs_n` at the same instant as the last falling `sck` edge, so both edges pass through the synchronizers together. The bench provokes this by changing both lines in one step at the end of a frame. It then checks three things: exactly one commit pulse appears, `frame_data` holds the sent word, and the output enable drops. A frame-table walk also covers the poll-only case (select pulsed with no clocks) and the over-length and under-length frames around that boundary.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;
  // Edge events of one synchronized input, all in the system clock domain.
  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } edge_t;
endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int                 WIDTH   = 3,
  parameter int                 STAGES  = 2,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [WIDTH-1:0]                     async_i,
  output spi_frame_pkg::edge_t [WIDTH-1:0]     ev_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    // chain[STAGES-1] is the synchronized level; chain[STAGES] is its previous value.
    logic [STAGES:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {(STAGES+1){RST_VAL[g]}};
      else        chain <= {chain[STAGES-1:0], async_i[g]};
    end
    assign ev_o[g].level = chain[STAGES-1];
    assign ev_o[g].rise  = chain[STAGES-1] & ~chain[STAGES];
    assign ev_o[g].fall  = ~chain[STAGES-1] & chain[STAGES];
  end
endmodule

// File: rtl/spi_rx_frame.sv
module spi_rx_frame #(
  parameter int FRAME_W = 16,
  localparam int CNT_W  = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic               sck_rise,
  input  logic               cs_rise,
  input  logic               mosi,
  output logic [FRAME_W-1:0] frame_data,
  output logic               frame_commit,
  output logic [CNT_W-1:0]   bit_cnt
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

  logic [FRAME_W-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q      <= '0;
      bit_cnt      <= '0;
      frame_data   <= '0;
      frame_commit <= 1'b0;
    end else begin
      frame_commit <= 1'b0;
      if (cs_rise) begin
        if (bit_cnt == FULL) begin
          frame_data   <= shift_q;
          frame_commit <= 1'b1;
        end
        bit_cnt <= '0;
      end else if (active && sck_rise && bit_cnt != FULL) begin
        shift_q <= {shift_q[FRAME_W-2:0], mosi};
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_tx_status.sv
module spi_tx_status #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic               sck_rise,
  input  logic               sck_fall,
  input  logic [FRAME_W-1:0] word_i,
  input  logic               flag_i,
  output logic               miso,
  output logic               miso_oe
);
  logic [FRAME_W-1:0] shift_q;
  logic               loaded_q;
  logic               shifted_q;
  logic               bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q   <= '0;
      loaded_q  <= 1'b0;
      shifted_q <= 1'b0;
      bit_q     <= 1'b0;
      miso_oe   <= 1'b0;
    end else begin
      miso_oe <= active;
      if (!active) begin
        loaded_q  <= 1'b0;
        shifted_q <= 1'b0;
      end else begin
        if (sck_rise && !loaded_q) begin
          shift_q  <= word_i;
          loaded_q <= 1'b1;
        end
        if (sck_fall && loaded_q) begin
          bit_q     <= shift_q[FRAME_W-1];
          shift_q   <= {shift_q[FRAME_W-2:0], 1'b0};
          shifted_q <= 1'b1;
        end
      end
    end
  end

  // Until the first falling edge the pin carries the live no-fault flag.
  assign miso = shifted_q ? bit_q : flag_i;
endmodule

// File: rtl/spi_frame_slave.sv
module spi_frame_slave #(
  parameter int FRAME_W     = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               sck,
  input  logic               mosi,
  output logic               miso,
  output logic               miso_oe,
  input  logic [FRAME_W-1:0] status0_i,
  input  logic [FRAME_W-1:0] status1_i,
  output logic [FRAME_W-1:0] frame_data,
  output logic               frame_commit
);
  import spi_frame_pkg::*;

  localparam int IDX_CS   = 0;
  localparam int IDX_SCK  = 1;
  localparam int IDX_MOSI = 2;

  edge_t [2:0]        ev;
  logic               cs_lvl;
  logic               active;
  logic               no_fault;
  logic [FRAME_W-1:0] word_sel;
  logic [CNT_W-1:0]   rx_cnt;

  spi_edge_sync #(
    .WIDTH   (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b001)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({mosi, sck, cs_n}),
    .ev_o    (ev)
  );

  assign cs_lvl   = ev[IDX_CS].level;
  assign active   = ~cs_lvl;
  assign no_fault = ~|(status0_i[FRAME_W-2:1] | status1_i[FRAME_W-2:1]);
  assign word_sel = {(frame_data[0] ? status1_i[FRAME_W-1:1] : status0_i[FRAME_W-1:1]),
                     no_fault};

  spi_rx_frame #(.FRAME_W(FRAME_W)) u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .active       (active),
    .sck_rise     (ev[IDX_SCK].rise),
    .cs_rise      (ev[IDX_CS].rise),
    .mosi         (ev[IDX_MOSI].level),
    .frame_data   (frame_data),
    .frame_commit (frame_commit),
    .bit_cnt      (rx_cnt)
  );

  spi_tx_status #(.FRAME_W(FRAME_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .sck_rise (ev[IDX_SCK].rise),
    .sck_fall (ev[IDX_SCK].fall),
    .word_i   (word_sel),
    .flag_i   (no_fault),
    .miso     (miso),
    .miso_oe  (miso_oe)
  );
endmodule

// File: rtl/spi_frame_slave_chk.sv
module spi_frame_slave_chk #(
  parameter int FRAME_W = 16,
  localparam int CNT_W  = $clog2(FRAME_W + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cs_n,
  input logic               miso_oe,
  input logic               frame_commit,
  input logic [FRAME_W-1:0] frame_data,
  input logic [CNT_W-1:0]   bit_cnt
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_commit |=> !frame_commit);

  assert_commit_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_commit |-> $past(bit_cnt) == FULL);

  assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frame_data) |-> frame_commit);

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= FULL);

  assert_oe_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n, 3) |-> !miso_oe);
endmodule

bind spi_frame_slave spi_frame_slave_chk #(.FRAME_W(FRAME_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cs_n         (cs_n),
  .miso_oe      (miso_oe),
  .frame_commit (frame_commit),
  .frame_data   (frame_data),
  .bit_cnt      (rx_cnt)
);

// File: tb/spi_frame_slave_tb.sv
module spi_frame_slave_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sck = 1'b0;
  logic        mosi = 1'b0;
  logic [15:0] status0 = '0;
  logic [15:0] status1 = '0;
  logic        miso, miso_oe, frame_commit;
  logic [15:0] frame_data;

  int n_checks = 0;
  int n_fails  = 0;
  logic        exp_sel  = 1'b0;
  logic [15:0] exp_data = '0;

  always #2 clk = ~clk;

  spi_frame_slave u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .status0_i(status0), .status1_i(status1),
    .frame_data(frame_data), .frame_commit(frame_commit)
  );

  // Entry: {bit count, payload, status0, status1}
  localparam logic [53:0] VEC [6] = '{
    {6'd16, 16'hA5C3, 16'h0000, 16'hFFFF},
    {6'd16, 16'h1234, 16'h8001, 16'h8000},
    {6'd20, 16'hFFFF, 16'h4002, 16'h0000},
    {6'd9,  16'h0000, 16'h1234, 16'h7FFE},
    {6'd16, 16'h8000, 16'h0010, 16'h0000},
    {6'd0,  16'h0000, 16'h8000, 16'h0000}
  };

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_frame(input int nbits, input logic [15:0] pay, input logic [15:0] s0,
                            input logic [15:0] s1, input bit swap_sts, input bit joint_end);
    logic        flag;
    logic [15:0] word;
    int          pulses;
    string       rq;
    status0 = s0;
    status1 = s1;
    flag = ~|(s0[14:1] | s1[14:1]);
    word = {(exp_sel ? s1[15:1] : s0[15:1]), flag};
    cs_n = 1'b0;
    wait_clks(8);
    check(miso_oe == 1'b1, "R6", miso_oe, 1);
    check(miso == flag, "R7", miso, flag);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 16) ? pay[15-i] : 1'b1;
      wait_clks(4);
      sck = 1'b1;
      wait_clks(8);
      if (i == 0 && swap_sts) begin
        status0 = ~s0;
        status1 = ~s1;
      end
      if (joint_end && i == nbits - 1) begin
        sck = 1'b0;
        cs_n = 1'b1;
      end else begin
        sck = 1'b0;
        wait_clks(8);
        if (i < 16) begin
          rq = swap_sts ? "R10" : (exp_sel ? "R9" : "R8");
          check(miso == word[15-i], rq, miso, word[15-i]);
        end
      end
    end
    mosi = 1'b0;
    cs_n = 1'b1;
    pulses = 0;
    for (int k = 0; k < 12; k++) begin
      wait_clks(1);
      if (frame_commit) pulses++;
    end
    check(miso_oe == 1'b0, "R6", miso_oe, 0);
    if (nbits >= 16) begin
      exp_data = pay;
      exp_sel  = pay[0];
      check(pulses == 1, "R5", pulses, 1);
    end else begin
      check(pulses == 0, "R4", pulses, 0);
    end
    rq = (nbits > 16) ? "R3" : ((nbits < 16) ? "R4" : "R2");
    check(frame_data == exp_data, rq, frame_data, exp_data);
    wait_clks(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    int pulses;
    wait_clks(5);
    // R1: reset state
    check(miso_oe == 1'b0, "R1", miso_oe, 0);
    check(frame_commit == 1'b0, "R1", frame_commit, 0);
    check(frame_data == 16'h0, "R1", frame_data, 0);
    rst_n = 1'b1;
    wait_clks(5);
    check(miso_oe == 1'b0, "R1", miso_oe, 0);

    for (int v = 0; v < 6; v++)
      send_frame(int'(VEC[v][53:48]), VEC[v][47:32], VEC[v][31:16], VEC[v][15:0], 1'b0, 1'b0);

    // R11: clock activity while deselected must not count toward a frame
    mosi = 1'b1;
    for (int t = 0; t < 20; t++) begin
      sck = 1'b1; wait_clks(6);
      sck = 1'b0; wait_clks(6);
    end
    check(miso_oe == 1'b0, "R11", miso_oe, 0);
    mosi = 1'b0;
    cs_n = 1'b0; wait_clks(8);
    cs_n = 1'b1;
    pulses = 0;
    for (int k = 0; k < 12; k++) begin
      wait_clks(1);
      if (frame_commit) pulses++;
    end
    check(pulses == 0, "R11", pulses, 0);
    check(frame_data == exp_data, "R11", frame_data, exp_data);

    // R10: status inputs change after the first rising edge
    send_frame(16, 16'h0F0F, 16'h2468, 16'h1357, 1'b1, 1'b0);
    send_frame(16, 16'hC3C2, 16'h0006, 16'h9ABC, 1'b1, 1'b0);

    // Select release together with the final falling clock edge
    send_frame(16, 16'h5A5B, 16'h1111, 16'h2222, 1'b0, 1'b1);
    send_frame(16, 16'h0001, 16'h0000, 16'h8000, 1'b0, 1'b0);

    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end
endmodule